// File: doc/BRIEF.md
# Parallel PRBS-7 Pattern Source

This block feeds test patterns to the parallel side of a serializer. Its main pattern is a pseudo-random sequence from a 7-stage maximal-length shift register. The register is stepped several bit positions in every enabled clock, so each clock yields one parallel word that holds the next consecutive bits of the serial sequence.

Two raw link-connectivity patterns are also offered: a steady all-ones word, and a slow alternating pattern in which whole words are all ones or all zeros and the level flips after a parameterized number of words. An all-zeros word can be chosen as well. None of these patterns passes through line coding.

A small state machine tracks the selected pattern and has these states: ST_IDLE (enable low), ST_PRBS, ST_ONES, ST_ALT and ST_ZERO. In every clock the next state is taken from the enable and mode inputs. ST_IDLE is entered whenever enable is low. Otherwise the mode selects the state: 2'b00 goes to ST_PRBS, 2'b01 to ST_ONES, 2'b10 to ST_ALT and 2'b11 to ST_ZERO. Any state can move to any other state in a single clock. Moving into ST_ALT from a different state is the restart transition of the alternating pattern.

Top module: `prbs7_pattern_gen`

## Requirements
- R1: While rst is high at a clock edge, data becomes 0, valid becomes 0 and the shift register is loaded with the seed 7'b1111111.
- R2: An edge with en low gives valid 0 and data 0, and it leaves the pseudo-random sequence position unchanged.
- R3: In mode 2'b00, each word holds the next WORD_W bits of the serial sequence b[n] = b[n-7] XOR b[n-6], with the oldest bit in bit 0. After reset the first seven bits are ones, so the first 8-bit word is 8'h7F.
- R4: The serial stream repeats every 127 bits. With WORD_W = 8, the 128th pseudo-random word after reset equals the 1st word.
- R5: In mode 2'b01, data is all ones.
- R6: In mode 2'b10, every bit of data equals a common level. That level is 1 for the first TOGGLE_DIV words and then inverts after each further TOGGLE_DIV consecutive words in this mode.
- R7: In mode 2'b11, data is all zeros.
- R8: Words in other modes and idle cycles do not advance the sequence. A later return to mode 2'b00 continues exactly where the stream stopped.
- R9: Results have a latency of one cycle. The en and mode values sampled at an edge determine data and valid right after that same edge, and valid is 1.
- R10: Entering mode 2'b10 from any other state or from idle restarts the alternating pattern at level 1 with a full count of TOGGLE_DIV words.
- R11: The shift register never holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Produce a word in this clock |
| mode | input | 2 | Pattern select: 00 PRBS-7, 01 ones, 10 alternating, 11 zeros |
| data | output | WORD_W | Parallel pattern word, bit 0 sent first |
| valid | output | 1 | data holds a word produced this cycle |

## Verification
Each result is due exactly one edge after the inputs that produced it, because data and valid are registered once. The driver changes en and mode on the falling edge and at the same moment pushes the word it expects into a queue. The monitor pops one item a short delay after each rising edge and compares it, so a check never races the edge that updates the output. The wrap check counts pseudo-random words from reset and compares word 128 with word 1.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;
    localparam int           SR_LEN  = 7;
    localparam logic [6:0]   SR_SEED = 7'b1111111;

    typedef enum logic [1:0] {
        MODE_PRBS = 2'b00,
        MODE_ONES = 2'b01,
        MODE_ALT  = 2'b10,
        MODE_ZERO = 2'b11
    } pat_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRBS,
        ST_ONES,
        ST_ALT,
        ST_ZERO
    } gen_state_e;
endpackage

// File: rtl/prbs7_step.sv
module prbs7_step #(
    parameter int WORD_W = 8
) (
    input  logic [6:0]        cur,
    output logic [WORD_W-1:0] word,
    output logic [6:0]        nxt
);
    // cur[k] is serial bit n+k; cur[0] is the oldest pending bit
    logic [6:0] walk;

    always_comb begin
        walk = cur;
        word = '0;
        for (int j = 0; j < WORD_W; j++) begin
            word[j] = walk[0];
            walk    = {walk[0] ^ walk[1], walk[6:1]};
        end
        nxt = walk;
    end
endmodule

// File: rtl/alt_pattern_div.sv
module alt_pattern_div #(
    parameter int TOGGLE_DIV = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic fresh,
    output logic level
);
    localparam int CNT_W = (TOGGLE_DIV < 2) ? 1 : $clog2(TOGGLE_DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TOGGLE_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_cur;
    logic             lvl_q;

    always_comb begin
        level   = fresh ? 1'b1 : lvl_q;
        cnt_cur = fresh ? '0 : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (fire) begin
            if (cnt_cur == LAST) begin
                cnt_q <= '0;
                lvl_q <= ~level;
            end else begin
                cnt_q <= cnt_cur + 1'b1;
                lvl_q <= level;
            end
        end
    end
endmodule

// File: rtl/pattern_mode_fsm.sv
module pattern_mode_fsm
    import prbs7_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] mode,
    output gen_state_e state_d,
    output logic       adv_sr,
    output logic       alt_fire,
    output logic       alt_fresh,
    output logic       emit
);
    gen_state_e state_q;

    always_comb begin
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (pat_mode_e'(mode))
                MODE_PRBS: state_d = ST_PRBS;
                MODE_ONES: state_d = ST_ONES;
                MODE_ALT:  state_d = ST_ALT;
                MODE_ZERO: state_d = ST_ZERO;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        adv_sr    = 1'b0;
        alt_fire  = 1'b0;
        alt_fresh = 1'b0;
        emit      = 1'b1;
        unique case (state_d)
            ST_IDLE: emit   = 1'b0;
            ST_PRBS: adv_sr = 1'b1;
            ST_ALT: begin
                alt_fire  = 1'b1;
                alt_fresh = (state_q != ST_ALT);
            end
            ST_ONES, ST_ZERO: ;
            default: emit = 1'b0;
        endcase
    end
endmodule

// File: rtl/prbs7_pattern_gen.sv
module prbs7_pattern_gen
    import prbs7_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int TOGGLE_DIV = 65536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        mode,
    output logic [WORD_W-1:0] data,
    output logic              valid
);
    gen_state_e        state_d;
    logic              adv_sr, alt_fire, alt_fresh, emit;
    logic              alt_level;
    logic [6:0]        sr_q, sr_nxt;
    logic [WORD_W-1:0] prbs_word, word_d, data_q;
    logic              valid_q;

    pattern_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .en(en), .mode(mode),
        .state_d(state_d), .adv_sr(adv_sr), .alt_fire(alt_fire),
        .alt_fresh(alt_fresh), .emit(emit)
    );

    prbs7_step #(.WORD_W(WORD_W)) u_step (
        .cur(sr_q), .word(prbs_word), .nxt(sr_nxt)
    );

    alt_pattern_div #(.TOGGLE_DIV(TOGGLE_DIV)) u_alt (
        .clk(clk), .rst(rst), .fire(alt_fire), .fresh(alt_fresh),
        .level(alt_level)
    );

    always_comb begin
        unique case (state_d)
            ST_PRBS: word_d = prbs_word;
            ST_ONES: word_d = '1;
            ST_ALT:  word_d = {WORD_W{alt_level}};
            ST_ZERO: word_d = '0;
            default: word_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= SR_SEED;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (adv_sr) sr_q <= sr_nxt;
            data_q  <= word_d;
            valid_q <= emit;
        end
    end

    assign data  = data_q;
    assign valid = valid_q;
endmodule

// File: rtl/prbs7_pattern_chk.sv
module prbs7_pattern_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [1:0]        mode,
    input logic [WORD_W-1:0] data,
    input logic              valid,
    input logic [6:0]        sr_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!valid && data == '0)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !en |=> (!valid && data == '0)); // R2
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) en |=> valid); // R9
    AST_ONES_WORD: assert property (@(posedge clk) disable iff (rst) (en && mode == 2'b01) |=> data == '1); // R5
    AST_ZERO_WORD: assert property (@(posedge clk) disable iff (rst) (en && mode == 2'b11) |=> data == '0); // R7
    AST_ALT_UNIFORM: assert property (@(posedge clk) disable iff (rst) (en && mode == 2'b10) |=> (data == '0 || data == '1)); // R6
    AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst) !(en && mode == 2'b00) |=> $stable(sr_q)); // R8
    AST_SR_NONZERO: assert property (@(posedge clk) disable iff (rst) sr_q != 7'd0); // R11
endmodule

bind prbs7_pattern_gen prbs7_pattern_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .mode(mode),
    .data(data), .valid(valid), .sr_q(sr_q)
);

// File: tb/sim_prbs7_pattern_gen.sv
module sim_prbs7_pattern_gen;
    localparam int W   = 8;
    localparam int DIV = 3;

    typedef struct {
        logic [W-1:0] data;
        logic         valid;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] data;
    logic         valid;

    int n_chk = 0;
    int n_bad = 0;
    exp_t q[$];

    // bench model state
    logic [6:0]   m_sr = 7'h7F;
    logic         m_lvl = 1'b1;
    int           m_cnt = 0;
    logic         m_in_alt = 1'b0;
    int           prbs_words = 0;
    logic [W-1:0] first_word = '0;

    prbs7_pattern_gen #(.WORD_W(W), .TOGGLE_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .data(data), .valid(valid)
    );

    always #10 clk = ~clk;

    task automatic check(input logic [W-1:0] got_d, input logic got_v,
                         input logic [W-1:0] exp_d, input logic exp_v, input string req);
        n_chk++;
        if (got_d !== exp_d || got_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: data=%h valid=%b expected data=%h valid=%b",
                     req, got_d, got_v, exp_d, exp_v);
        end
    endtask

    // serial reference: one bit at a time
    function automatic logic [W-1:0] ref_word();
        logic [W-1:0] w;
        for (int j = 0; j < W; j++) begin
            w[j] = m_sr[0];
            m_sr = {m_sr[0] ^ m_sr[1], m_sr[6:1]};
        end
        return w;
    endfunction

    task automatic drive(input logic e, input logic [1:0] md, input string req);
        exp_t it;
        @(negedge clk);
        en = e;
        mode = md;
        it.valid = e;
        it.req = req;
        if (!e) begin
            it.data = '0;
            m_in_alt = 1'b0;
        end else begin
            case (md)
                2'b00: begin
                    it.data = ref_word();
                    prbs_words++;
                    if (prbs_words == 1) first_word = it.data;
                    if (prbs_words == 128) begin
                        it.req = "R4";
                        n_chk++;
                        if (it.data !== first_word) begin
                            n_bad++;
                            $display("FAIL R4: model word128=%h expected=%h", it.data, first_word);
                        end
                    end
                    m_in_alt = 1'b0;
                end
                2'b01: begin it.data = '1; m_in_alt = 1'b0; end
                2'b11: begin it.data = '0; m_in_alt = 1'b0; end
                default: begin
                    if (!m_in_alt) begin m_lvl = 1'b1; m_cnt = 0; end
                    it.data = {W{m_lvl}};
                    m_cnt++;
                    if (m_cnt == DIV) begin m_cnt = 0; m_lvl = ~m_lvl; end
                    m_in_alt = 1'b1;
                end
            endcase
        end
        q.push_back(it);
    endtask

    // monitor: results appear one edge after the driven inputs
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            check(data, valid, it.data, it.valid, it.req);
        end
    end

    initial begin
        #4000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(data, valid, '0, 1'b0, "R1");
        @(negedge clk);
        rst = 1'b0;
        // R3: first word 8'h7F, then continuing stream
        for (int i = 0; i < 10; i++) drive(1'b1, 2'b00, "R3");
        // R2: idle cycles
        drive(1'b0, 2'b00, "R2");
        drive(1'b0, 2'b10, "R2");
        // R5
        for (int i = 0; i < 3; i++) drive(1'b1, 2'b01, "R5");
        // R8: resume stream where it stopped
        for (int i = 0; i < 5; i++) drive(1'b1, 2'b00, "R8");
        // R7
        for (int i = 0; i < 2; i++) drive(1'b1, 2'b11, "R7");
        // R6: level 1 x3, 0 x3, 1 x2
        for (int i = 0; i < 8; i++) drive(1'b1, 2'b10, "R6");
        drive(1'b1, 2'b00, "R8");
        // R10: re-entry restarts at level 1
        for (int i = 0; i < 4; i++) drive(1'b1, 2'b10, "R10");
        drive(1'b0, 2'b10, "R2");
        drive(1'b1, 2'b10, "R10");
        // R9 with R4: run to word 128
        while (prbs_words < 130) drive(1'b1, 2'b00, "R9");
        drive(1'b0, 2'b00, "R2");
        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule